// File: doc/BRIEF.md
# Single-Upset-Correcting Five-Phase Sequencer

This block is a five-phase controller that steps through its phases in a fixed ring, one step per clock in which `advance` is high. Its state register holds six bits. Each phase is stored as a codeword, and every pair of codewords differs in at least three bit positions. A single flipped bit in the register therefore always lies closer to the intended codeword than to any other. The decoder treats such a "companion" code exactly as it treats its codeword. The outputs and the next transition are those of the intended phase, so after a strike the sequence continues where it was and is not thrown back to its start.

Each cycle the register is rewritten with an exact codeword, so a corrected upset is gone after one clock. While the register holds a companion code, the block raises a one-cycle correction indication. A code that lies two or more bits from every codeword cannot be attributed to a phase. The block reports it as uncorrectable and sends the machine back to phase 0. An XOR mask input applies to the value written into the register, so a testbench can place any single-bit or multi-bit upset into any phase.

Top module: `hd3_sc_fsm`

## Requirements
- R1: While `rst_n` is low, and after its release with no other stimulus, `phase` is 0, `busy` is low, and `corr_event` and `uncorr_err` are both low.
- R2: With a clean register and `upset_mask` zero, a clock edge with `advance` high moves `phase` from p to (p+1) mod 5. With `advance` low, the edge leaves `phase` unchanged.
- R3: Phases 0 to 4 are stored as the codewords 000000, 000111, 111000, 011011 and 101101 (bit 5 on the left). Any edge with `upset_mask` zero writes an exact codeword, so `corr_event` and `uncorr_err` are low in the following cycle.
- R4: When the register holds a code exactly one bit away from the codeword of phase p, `phase` reads p and `corr_event` is high. `corr_event` and `uncorr_err` are never high together.
- R5: The transition taken from a companion code is the one its phase would take: (p+1) mod 5 with `advance` high.
- R6: A code at distance two or more from every codeword sets `uncorr_err`, reads as `phase` 0 with `busy` low, and sends the next clean edge to phase 0 whatever `advance` is.
- R7: The register captures the next codeword XOR `upset_mask`, so a mask bit at position k inverts stored bit k for that capture only.
- R8: `busy` is high exactly while `phase` is 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to phase 0 |
| advance | input | 1 | Step to the next phase at the coming edge |
| upset_mask | input | 6 | Bits inverted in the value captured by the state register |
| phase | output | 3 | Decoded phase index, 0 to 4 |
| busy | output | 1 | High in phases 1, 2 and 3 |
| corr_event | output | 1 | Register holds a companion code (single upset corrected) |
| uncorr_err | output | 1 | Register holds a code not attributable to any phase |

## Verification
The assertions run on every cycle. They check that the two flags never rise together and that a clean capture always leaves both flags low on the next cycle. They also check the ring step and the hold under `advance`, the return to phase 0 from an unrecognised code, and that `busy` stays low there. Only the bench scenarios can show what happens with masks. The bench walks all 64 masks over each of the five phases and compares the decoded phase and the flags with a nearest-codeword computation of its own. The same sweep shows that double upsets which land next to another codeword are taken as that codeword, and that the step out of every companion code matches its phase.

// File: rtl/hd3_fsm_pkg.sv
package hd3_fsm_pkg;

    localparam int unsigned N_PHASES = 5;
    localparam int unsigned CODE_W   = 6;
    localparam int unsigned IDX_W    = $clog2(N_PHASES);

    // Distance-3 storage codes for the five phases.
    function automatic logic [CODE_W-1:0] phase_code(input int unsigned idx);
        logic [CODE_W-1:0] c;
        case (idx)
            0:       c = 6'b000000;
            1:       c = 6'b000111;
            2:       c = 6'b111000;
            3:       c = 6'b011011;
            4:       c = 6'b101101;
            default: c = 6'b000000;
        endcase
        return c;
    endfunction

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } state_t;

endpackage

// File: rtl/hd3_code_decode.sv
module hd3_code_decode
    import hd3_fsm_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              corrected_o,
    output logic              illegal_o
);

    logic [N_PHASES-1:0] exact;
    logic [N_PHASES-1:0] near;

    // One distance comparator per phase codeword.
    for (genvar g = 0; g < N_PHASES; g++) begin : g_dist
        logic [CODE_W-1:0] diff;
        assign diff     = code_i ^ phase_code(g);
        assign exact[g] = (diff == '0);
        assign near[g]  = ($countones(diff) <= 1);
    end

    always_comb begin
        idx_o = '0;
        for (int i = N_PHASES - 1; i >= 0; i--) begin
            if (near[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign illegal_o   = ~|near;
    assign corrected_o = (|near) & ~(|exact);

endmodule

// File: rtl/hd3_next_phase.sv
module hd3_next_phase
    import hd3_fsm_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic             illegal_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PHASES - 1);

    always_comb begin
        if (illegal_i) begin
            idx_o = '0;
        end else if (advance_i) begin
            idx_o = (idx_i == LAST) ? '0 : idx_i + 1'b1;
        end else begin
            idx_o = idx_i;
        end
    end

endmodule

// File: rtl/hd3_sc_fsm.sv
module hd3_sc_fsm
    import hd3_fsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [CODE_W-1:0] upset_mask,
    output logic [IDX_W-1:0]  phase,
    output logic              busy,
    output logic              corr_event,
    output logic              uncorr_err
);

    state_t           st_d;
    state_t           st_q;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] nxt_idx;
    logic             cur_corr;
    logic             cur_ill;

    hd3_code_decode u_decode (
        .code_i      (st_q.code),
        .idx_o       (cur_idx),
        .corrected_o (cur_corr),
        .illegal_o   (cur_ill)
    );

    hd3_next_phase u_next (
        .idx_i     (cur_idx),
        .illegal_i (cur_ill),
        .advance_i (advance),
        .idx_o     (nxt_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.code = phase_code(int'(nxt_idx)) ^ upset_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= phase_code(0);
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = cur_idx;
    assign busy       = !cur_ill && (cur_idx != '0) && (cur_idx != IDX_W'(N_PHASES - 1));
    assign corr_event = cur_corr;
    assign uncorr_err = cur_ill;

endmodule

// File: rtl/hd3_sc_fsm_chk.sv
module hd3_sc_fsm_chk
    import hd3_fsm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              advance,
    input logic [CODE_W-1:0] upset_mask,
    input logic [IDX_W-1:0]  phase,
    input logic              busy,
    input logic              corr_event,
    input logic              uncorr_err
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PHASES - 1);

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_event && uncorr_err));

    p_clean_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upset_mask == '0) |=> (!corr_event && !uncorr_err));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upset_mask == '0 && !uncorr_err && advance) |=>
        (phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upset_mask == '0 && !uncorr_err && !advance) |=> $stable(phase));

    p_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uncorr_err && upset_mask == '0) |=> (phase == '0));

    p_idle_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_err |-> !busy);

endmodule

bind hd3_sc_fsm hd3_sc_fsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .upset_mask (upset_mask),
    .phase      (phase),
    .busy       (busy),
    .corr_event (corr_event),
    .uncorr_err (uncorr_err)
);

// File: tb/hd3_sc_fsm_bench.sv
module hd3_sc_fsm_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       advance = 1'b0;
    logic [5:0] upset_mask = '0;
    logic [2:0] phase;
    logic       busy;
    logic       corr_event;
    logic       uncorr_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hd3_sc_fsm u_hd3_sc_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .upset_mask (upset_mask),
        .phase      (phase),
        .busy       (busy),
        .corr_event (corr_event),
        .uncorr_err (uncorr_err)
    );

    // Codewords as stated in R3.
    function automatic logic [5:0] cw(input int p);
        case (p)
            0: return 6'b000000;
            1: return 6'b000111;
            2: return 6'b111000;
            3: return 6'b011011;
            default: return 6'b101101;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reach(input int p);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        advance = 1'b1;
        repeat (p) @(negedge clk);
        advance = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R1: during reset
        check(phase == 0, "R1 phase", phase, 0);
        check(!busy && !corr_event && !uncorr_err, "R1 flags", {busy, corr_event, uncorr_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(phase == 0 && !corr_event && !uncorr_err, "R1 after release", phase, 0);

        for (int s = 0; s < 5; s++) begin
            for (int m = 0; m < 64; m++) begin
                logic [5:0] code;
                int dec;
                bit legal;
                bit is_exact;
                reach(s);
                // R2 hold with advance low, R3 clean register, R8 busy
                @(negedge clk);
                check(phase == s, "R2 hold", phase, s);
                check(!corr_event && !uncorr_err, "R3 clean", {corr_event, uncorr_err}, 0);
                check(busy == (s >= 1 && s <= 3), "R8 busy", busy, (s >= 1 && s <= 3));
                // R7 inject mask
                upset_mask = 6'(m);
                @(negedge clk);
                upset_mask = '0;
                code = cw(s) ^ 6'(m);
                dec = 0; legal = 0; is_exact = 0;
                for (int j = 0; j < 5; j++) begin
                    if ($countones(code ^ cw(j)) <= 1) begin
                        dec = j; legal = 1;
                        is_exact = (code == cw(j));
                    end
                end
                if (legal) begin
                    // R4 companion decodes to its phase, R7 mask applied
                    check(phase == dec, "R4 R7 phase", phase, dec);
                    check(corr_event == !is_exact, "R4 corr_event", corr_event, !is_exact);
                    check(!uncorr_err, "R4 no uncorr", uncorr_err, 0);
                    check(busy == (dec >= 1 && dec <= 3), "R8 busy companion", busy, (dec >= 1 && dec <= 3));
                end else begin
                    check(uncorr_err && !corr_event, "R6 flag", {uncorr_err, corr_event}, 2);
                    check(phase == 0 && !busy, "R6 phase", phase, 0);
                end
                // R5 / R6 next transition
                advance = 1'b1;
                @(negedge clk);
                advance = 1'b0;
                if (legal) begin
                    check(phase == (dec + 1) % 5, "R5 step", phase, (dec + 1) % 5);
                end else begin
                    check(phase == 0, "R6 recover", phase, 0);
                end
                check(!corr_event && !uncorr_err, "R3 rewrite", {corr_event, uncorr_err}, 0);
            end
        end

        // R2 full ring wrap
        reach(4);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        check(phase == 0, "R2 wrap", phase, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule